// File: doc/BRIEF.md
# Two-Slot Packet Transmit Buffer for an IN Endpoint

This block buffers outgoing packets for one bulk or interrupt IN endpoint of a USB function. The processor pushes payload bytes one at a time into a circular byte store. It then commits a byte count, and that closes one packet slot. At most two committed packets are held at once. The processor fills the second slot while the first one waits to be sent or is being sent.

The serial engine raises a token strobe when an IN token arrives and gets a registered reply one cycle later: STALL, NAK or DATA. A DATA reply carries the packet length and the data PID. The engine then pulls bytes one at a time. It closes the transfer with an ACK strobe or a failure strobe. On ACK the slot is released and the next slot becomes current. On failure the read position returns to the start of the same slot, so the retry carries the same bytes and the same PID. The PID is tied to the slot: slot 0 always sends DATA0 and slot 1 always sends DATA1. This makes the toggle follow the slot alternation and leaves it out of software's hands. Four sticky event flags report conditions to software and drive one interrupt line.

Top module: `dset_ep_tx_fifo`

## Requirements
- R1: After reset, no slot is held, all four flags and `irq` are 0, and `resp_valid` and `rd_valid` are 0.
- R2: A count commit (`cnt_valid`) turns that many of the oldest uncommitted bytes into one held slot, and `sets_held` rises by one. A commit is refused when its count exceeds MAX_PKT, exceeds the uncommitted bytes, or when two slots are already held. A refused commit sets overflow flag bit 3 and leaves `sets_held` unchanged.
- R3: A byte written while DEPTH bytes are unreleased is dropped and sets flag bit 3. A dropped byte never appears in a later packet.
- R4: The cycle after `in_tok`, `resp_valid` is 1. If `ep_stall` is high, `resp_kind` is STALL (code 1), whatever the other conditions are.
- R5: Without stall, the reply is NAK (code 0) when `ep_oe` is low, when no slot is held, or when a transfer is still awaiting its handshake.
- R6: Otherwise the reply is DATA (code 2). `resp_len` is the current slot's count and `resp_pid` is the slot index (0 = DATA0, 1 = DATA1). The first slot committed after reset is slot 0, and commits alternate between the slots.
- R7: Each `rd_req` during a transfer gives `rd_valid` one cycle later, with the slot's bytes in the order they were written.
- R8: An `rd_req` after all of the slot's bytes have been read sets underrun flag bit 2 and returns `rd_data` = 0.
- R9: `hs_ack` during a transfer releases the slot, lowers `sets_held` and sets flag bit 0. The next DATA reply sends the other slot with the other PID.
- R10: `hs_fail` during a transfer sets flag bit 1 and rewinds the slot. The next DATA reply has the same PID and length and replays the same bytes.
- R11: Flags stay set until a 1 is written to their bit of `flag_clr`. A flag event in the same cycle as its clear leaves the flag set. `irq` is the OR of the four flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Push one payload byte |
| wr_data | input | 8 | Payload byte |
| cnt_valid | input | 1 | Commit a packet count |
| cnt_value | input | CW | Packet byte count, CW = clog2(MAX_PKT+1) |
| ep_oe | input | 1 | Endpoint may send data |
| ep_stall | input | 1 | Force STALL replies |
| in_tok | input | 1 | IN token strobe from serial engine |
| rd_req | input | 1 | Engine requests next byte |
| hs_ack | input | 1 | Host acknowledged the packet |
| hs_fail | input | 1 | Transfer failed (timeout or bus error) |
| flag_clr | input | 4 | Write-one-to-clear mask for flags |
| resp_valid | output | 1 | Reply to token is valid |
| resp_kind | output | 2 | 0 NAK, 1 STALL, 2 DATA |
| resp_pid | output | 1 | 0 DATA0, 1 DATA1 (DATA replies) |
| resp_len | output | CW | Packet length (DATA replies) |
| rd_valid | output | 1 | Read byte valid |
| rd_data | output | 8 | Read byte |
| sets_held | output | 2 | Committed slots held (0..2) |
| flags | output | 4 | bit0 ack, bit1 error, bit2 underrun, bit3 overflow |
| irq | output | 1 | Any flag set |

## Verification
The bench builds the block with DEPTH = 16 and MAX_PKT = 8, so the store fills after a handful of writes and a full-size packet takes eight reads. With these values the full-store drop, the maximum-length packet, the two-slot refusal and the wrap of the circular pointers all occur within a short sequence. The same sequence also walks the PID alternation through several ACK releases and a failed-then-replayed transfer.

// File: rtl/eptx_pkg.sv
package eptx_pkg;

  typedef enum logic [1:0] {
    RSP_NAK   = 2'd0,
    RSP_STALL = 2'd1,
    RSP_DATA  = 2'd2
  } rsp_e;

  localparam int FL_ACK = 0;
  localparam int FL_ERR = 1;
  localparam int FL_UNR = 2;
  localparam int FL_OVF = 3;
  localparam int NFLAG  = 4;

  // Reply priority: stall, then reasons to refuse, then data.
  function automatic rsp_e pick_rsp(input logic stall, input logic oe,
                                    input logic have_set, input logic busy);
    if (stall) return RSP_STALL;
    if (!oe || !have_set || busy) return RSP_NAK;
    return RSP_DATA;
  endfunction

endpackage

// File: rtl/eptx_store.sv
module eptx_store #(
  parameter int DEPTH = 64,
  parameter int CW    = 7,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [7:0]    push_data,
  input  logic          pop,
  input  logic          rewind,
  input  logic          release_en,
  input  logic [CW-1:0] release_len,
  output logic [7:0]    head_byte,
  output logic [PW-1:0] fill,
  output logic          full
);

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wr_ptr;
  logic [PW-1:0] mark;
  logic [AW-1:0] rd_ptr;

  function automatic logic [PW-1:0] advance(input logic [PW-1:0] p,
                                            input logic [CW-1:0] n);
    return p + PW'(n);
  endfunction

  logic [PW-1:0] mark_next;
  assign mark_next = advance(mark, release_len);

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr[AW-1:0]] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      mark   <= '0;
      rd_ptr <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (release_en) begin
        mark   <= mark_next;
        rd_ptr <= mark_next[AW-1:0];
      end else if (rewind) begin
        rd_ptr <= mark[AW-1:0];
      end else if (pop) begin
        rd_ptr <= rd_ptr + 1'b1;
      end
    end
  end

  assign head_byte = mem[rd_ptr];
  assign fill      = wr_ptr - mark;
  assign full      = (fill == PW'(DEPTH));

endmodule

// File: rtl/eptx_sets.sv
module eptx_sets #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit,
  input  logic [CW-1:0] commit_len,
  input  logic          release_en,
  output logic [1:0]    held,
  output logic [CW-1:0] head_len,
  output logic          wr_sel,
  output logic          rd_sel
);

  logic [CW-1:0] len_q [2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q[0] <= '0;
      len_q[1] <= '0;
      wr_sel   <= 1'b0;
      rd_sel   <= 1'b0;
      held     <= 2'd0;
    end else begin
      if (commit) begin
        len_q[wr_sel] <= commit_len;
        wr_sel        <= ~wr_sel;
      end
      if (release_en) rd_sel <= ~rd_sel;
      held <= held + {1'b0, commit} - {1'b0, release_en};
    end
  end

  assign head_len = len_q[rd_sel];

endmodule

// File: rtl/dset_ep_tx_fifo.sv
module dset_ep_tx_fifo
  import eptx_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int MAX_PKT = 64,
  localparam int CW     = $clog2(MAX_PKT + 1),
  localparam int PW     = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [7:0]    wr_data,
  input  logic          cnt_valid,
  input  logic [CW-1:0] cnt_value,
  input  logic          ep_oe,
  input  logic          ep_stall,
  input  logic          in_tok,
  input  logic          rd_req,
  input  logic          hs_ack,
  input  logic          hs_fail,
  input  logic [3:0]    flag_clr,
  output logic          resp_valid,
  output logic [1:0]    resp_kind,
  output logic          resp_pid,
  output logic [CW-1:0] resp_len,
  output logic          rd_valid,
  output logic [7:0]    rd_data,
  output logic [1:0]    sets_held,
  output logic [3:0]    flags,
  output logic          irq
);

  logic [7:0]    head_byte;
  logic [PW-1:0] fill;
  logic          full;
  logic [1:0]    held;
  logic [CW-1:0] head_len;
  logic          wr_sel, rd_sel;
  logic [PW-1:0] pend;
  logic [CW-1:0] rd_cnt;
  logic          busy;

  // Named events, also observed by the checker.
  logic push_ok, commit_ok, ovf_evt, send_evt, pop_evt, unr_evt;
  logic ack_evt, fail_evt;
  rsp_e tok_kind;

  function automatic logic commit_allowed(input logic [CW-1:0] n,
                                          input logic [PW-1:0] avail,
                                          input logic [1:0] h);
    return (h != 2'd2) && (int'(n) <= MAX_PKT) && (int'(n) <= int'(avail));
  endfunction

  assign push_ok   = wr_valid && !full;
  assign commit_ok = cnt_valid && commit_allowed(cnt_value, pend, held);
  assign ovf_evt   = (wr_valid && full) || (cnt_valid && !commit_ok);
  assign tok_kind  = pick_rsp(ep_stall, ep_oe, held != 2'd0, busy);
  assign send_evt  = in_tok && (tok_kind == RSP_DATA);
  assign pop_evt   = rd_req && busy && (rd_cnt < head_len);
  assign unr_evt   = rd_req && busy && !(rd_cnt < head_len);
  assign ack_evt   = hs_ack && busy;
  assign fail_evt  = hs_fail && busy && !hs_ack;

  eptx_store #(.DEPTH(DEPTH), .CW(CW)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .push        (push_ok),
    .push_data   (wr_data),
    .pop         (pop_evt),
    .rewind      (fail_evt),
    .release_en  (ack_evt),
    .release_len (head_len),
    .head_byte   (head_byte),
    .fill        (fill),
    .full        (full)
  );

  eptx_sets #(.CW(CW)) u_sets (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit     (commit_ok),
    .commit_len (cnt_value),
    .release_en (ack_evt),
    .held       (held),
    .head_len   (head_len),
    .wr_sel     (wr_sel),
    .rd_sel     (rd_sel)
  );

  logic [NFLAG-1:0] flag_set;
  always_comb begin
    flag_set         = '0;
    flag_set[FL_ACK] = ack_evt;
    flag_set[FL_ERR] = fail_evt;
    flag_set[FL_UNR] = unr_evt;
    flag_set[FL_OVF] = ovf_evt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend       <= '0;
      rd_cnt     <= '0;
      busy       <= 1'b0;
      resp_valid <= 1'b0;
      resp_kind  <= RSP_NAK;
      resp_pid   <= 1'b0;
      resp_len   <= '0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      flags      <= '0;
    end else begin
      pend <= pend + PW'(push_ok) - (commit_ok ? PW'(cnt_value) : '0);
      if (send_evt)                 busy <= 1'b1;
      else if (ack_evt || fail_evt) busy <= 1'b0;
      if (send_evt || fail_evt) rd_cnt <= '0;
      else if (pop_evt)         rd_cnt <= rd_cnt + 1'b1;
      resp_valid <= in_tok;
      resp_kind  <= tok_kind;
      resp_pid   <= send_evt ? rd_sel : 1'b0;
      resp_len   <= send_evt ? head_len : '0;
      rd_valid   <= rd_req && busy;
      rd_data    <= pop_evt ? head_byte : 8'h00;
      flags      <= (flags & ~flag_clr) | flag_set;
    end
  end

  assign sets_held = held;
  assign irq       = |flags;

endmodule

// File: rtl/eptx_chk.sv
module eptx_chk #(
  parameter int DEPTH = 64,
  parameter int CW    = 7,
  parameter int PW    = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic          in_tok,
  input logic          ep_stall,
  input logic          ep_oe,
  input logic          rd_req,
  input logic          resp_valid,
  input logic [1:0]    resp_kind,
  input logic [CW-1:0] resp_len,
  input logic          rd_valid,
  input logic [7:0]    rd_data,
  input logic [1:0]    sets_held,
  input logic [3:0]    flags,
  input logic [PW-1:0] fill,
  input logic          full,
  input logic          ack_evt,
  input logic          fail_evt,
  input logic          unr_evt,
  input logic          rd_sel
);

  a_r2_held_bound: assert property (@(posedge clk) disable iff (!rst_n)
    sets_held <= 2'd2);

  a_r3_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fill) <= DEPTH);

  a_r3_full_write_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && full |=> flags[3]);

  a_r4_stall_wins: assert property (@(posedge clk) disable iff (!rst_n)
    in_tok && ep_stall |=> resp_valid && resp_kind == 2'd1);

  a_r5_nak_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    in_tok && !ep_stall && !ep_oe |=> resp_kind == 2'd0 && resp_len == '0);

  a_r7_read_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_req));

  a_r8_underrun_zero: assert property (@(posedge clk) disable iff (!rst_n)
    unr_evt |=> flags[2] && rd_valid && rd_data == 8'h00);

  a_r9_ack_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ack_evt |=> flags[0] && rd_sel != $past(rd_sel));

  a_r10_fail_keeps_pid: assert property (@(posedge clk) disable iff (!rst_n)
    fail_evt |=> flags[1] && $stable(rd_sel));

endmodule

bind dset_ep_tx_fifo eptx_chk #(.DEPTH(DEPTH), .CW(CW), .PW(PW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_valid   (wr_valid),
  .in_tok     (in_tok),
  .ep_stall   (ep_stall),
  .ep_oe      (ep_oe),
  .rd_req     (rd_req),
  .resp_valid (resp_valid),
  .resp_kind  (resp_kind),
  .resp_len   (resp_len),
  .rd_valid   (rd_valid),
  .rd_data    (rd_data),
  .sets_held  (sets_held),
  .flags      (flags),
  .fill       (fill),
  .full       (full),
  .ack_evt    (ack_evt),
  .fail_evt   (fail_evt),
  .unr_evt    (unr_evt),
  .rd_sel     (rd_sel)
);

// File: tb/sim_dset_ep_tx_fifo.sv
`timescale 1ns/1ps
module sim_dset_ep_tx_fifo;
  localparam int DEPTH = 16;
  localparam int MAXP  = 8;
  localparam int CW    = $clog2(MAXP + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_valid = 0, cnt_valid = 0, ep_oe = 0, ep_stall = 0;
  logic in_tok = 0, rd_req = 0, hs_ack = 0, hs_fail = 0;
  logic [7:0] wr_data = 0;
  logic [CW-1:0] cnt_value = 0;
  logic [3:0] flag_clr = 0;
  logic resp_valid, resp_pid, rd_valid, irq;
  logic [1:0] resp_kind, sets_held;
  logic [CW-1:0] resp_len;
  logic [7:0] rd_data;
  logic [3:0] flags;

  int checks = 0, fails = 0;
  logic done = 0;
  logic [7:0] exp_q[$];

  always #10 clk = ~clk;  // 50 MHz

  dset_ep_tx_fifo #(.DEPTH(DEPTH), .MAX_PKT(MAXP)) u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: every returned byte is matched to the next expected one.
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) chk("R7 unexpected byte", 32'(rd_data), 32'hFFFF);
      else chk("R7 byte order", 32'(rd_data), 32'(exp_q.pop_front()));
    end
  end

  task automatic push_byte(input logic [7:0] b);
    wr_valid = 1; wr_data = b; @(negedge clk); wr_valid = 0;
  endtask

  task automatic commit(input int n);
    cnt_valid = 1; cnt_value = CW'(n); @(negedge clk); cnt_valid = 0;
  endtask

  task automatic token(input string req, input int kind, input int pid, input int len);
    in_tok = 1; @(negedge clk); in_tok = 0;
    chk({req, " resp_valid"}, 32'(resp_valid), 1);
    chk({req, " kind"}, 32'(resp_kind), 32'(kind));
    if (kind == 2) begin
      chk({req, " pid"}, 32'(resp_pid), 32'(pid));
      chk({req, " len"}, 32'(resp_len), 32'(len));
    end
  endtask

  task automatic read_expect(input logic [7:0] b);
    exp_q.push_back(b); rd_req = 1; @(negedge clk); rd_req = 0;
  endtask

  task automatic handshake(input logic ok);
    if (ok) hs_ack = 1; else hs_fail = 1;
    @(negedge clk); hs_ack = 0; hs_fail = 0;
  endtask

  task automatic clear_all;
    flag_clr = 4'hF; @(negedge clk); flag_clr = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 flags", 32'(flags), 0);
    chk("R1 held", 32'(sets_held), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 resp_valid", 32'(resp_valid), 0);
    chk("R1 rd_valid", 32'(rd_valid), 0);

    // R5 NAK with nothing held, with and without output enable
    token("R5 off-empty", 0, 0, 0);
    ep_oe = 1;
    token("R5 empty", 0, 0, 0);

    // R2 commit of five bytes
    for (int i = 0; i < 5; i++) push_byte(8'hA0 + 8'(i));
    commit(5);
    chk("R2 held after commit", 32'(sets_held), 1);

    ep_oe = 0;
    token("R5 oe low", 0, 0, 0);
    ep_oe = 1; ep_stall = 1;
    token("R4 stall", 1, 0, 0);
    ep_stall = 0;

    // R6 first slot is DATA0
    token("R6 first data", 2, 0, 5);
    token("R5 busy", 0, 0, 0);
    for (int i = 0; i < 5; i++) read_expect(8'hA0 + 8'(i));
    read_expect(8'h00);
    chk("R8 underrun flag", 32'(flags[2]), 1);

    // R10 failure then replay
    handshake(1'b0);
    chk("R10 error flag", 32'(flags[1]), 1);
    token("R10 replay", 2, 0, 5);
    for (int i = 0; i < 5; i++) read_expect(8'hA0 + 8'(i));
    handshake(1'b1);
    chk("R9 ack flag", 32'(flags[0]), 1);
    chk("R9 held after ack", 32'(sets_held), 0);
    chk("R11 irq set", 32'(irq), 1);
    clear_all();
    chk("R11 cleared", 32'(flags), 0);
    chk("R11 irq clear", 32'(irq), 0);

    // R2 two slots, refusals
    for (int i = 0; i < 3; i++) push_byte(8'hB0 + 8'(i));
    commit(3);
    for (int i = 0; i < 8; i++) push_byte(8'hC0 + 8'(i));
    commit(8);
    chk("R2 two held", 32'(sets_held), 2);
    commit(0);
    chk("R2 refuse third", 32'(flags[3]), 1);
    chk("R2 held unchanged", 32'(sets_held), 2);
    clear_all();
    push_byte(8'hD0);
    token("R6 second slot", 2, 1, 3);
    for (int i = 0; i < 3; i++) read_expect(8'hB0 + 8'(i));
    handshake(1'b1);
    commit(2);
    chk("R2 refuse short count", 32'(flags[3]), 1);
    chk("R2 held after refuse", 32'(sets_held), 1);
    token("R9 next slot", 2, 0, 8);
    for (int i = 0; i < 8; i++) read_expect(8'hC0 + 8'(i));
    handshake(1'b1);
    clear_all();

    // R3 fill to DEPTH, extra byte dropped
    for (int i = 0; i < 15; i++) push_byte(8'hE0 + 8'(i));
    chk("R3 no overflow yet", 32'(flags[3]), 0);
    push_byte(8'hEF);
    chk("R3 overflow", 32'(flags[3]), 1);
    clear_all();
    commit(8);
    token("R6 wrap slot", 2, 1, 8);
    read_expect(8'hD0);
    for (int i = 0; i < 7; i++) read_expect(8'hE0 + 8'(i));
    handshake(1'b1);
    commit(8);
    token("R9 after wrap", 2, 0, 8);
    for (int i = 7; i < 15; i++) read_expect(8'hE0 + 8'(i));
    read_expect(8'h00);
    chk("R3 dropped byte absent", 32'(flags[2]), 1);
    handshake(1'b1);
    chk("R9 held zero", 32'(sets_held), 0);
    clear_all();

    // R11 event wins over clear in the same cycle
    cnt_valid = 1; cnt_value = 1; flag_clr = 4'b1000;
    @(negedge clk);
    cnt_valid = 0; flag_clr = 0;
    chk("R11 set wins", 32'(flags[3]), 1);
    clear_all();
    chk("R11 clear after", 32'(flags[3]), 0);

    chk("R7 queue drained", 32'(exp_q.size()), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule